// File: doc/BRIEF.md
# Byte-Bus 16-bit Up/Down Counter

This block is a 16-bit counter that counts up or down on a timer tick. Software reaches it over an 8-bit register bus that has two locations, a low byte and a high byte. The high byte is never touched directly. Every access to the high location goes to an 8-bit holding latch instead. A read of the low location returns the low byte and, in the same cycle, captures the counter's upper byte into that latch. A write to the low location loads all 16 bits in one clock: the low byte comes from the bus and the upper byte comes from the latch. This makes a full-width transfer atomic even though the bus is only 8 bits wide.

Counting is paced by a tick input and gated by a clock-select field, where zero means the counter is stopped. A direction input chooses up or down, and a clear input zeroes the counter on a tick. A bus write to the low location beats both clear and count in the same cycle. Two combinational flags report end of range: one for the counter at zero, and one for the counter equal to a supplied TOP value. A sticky overflow flag records an upward wrap and is cleared by a write-one-to-clear strobe.

Top module: `bytebus_counter`

## Requirements
- R1: A write to the high location (`bus_addr`=1) changes only the holding latch and never the counter. A read of the high location returns the latch contents combinationally.
- R2: A read of the low location (`bus_addr`=0) returns counter bits 7:0 combinationally. At the next edge the latch takes counter bits 15:8.
- R3: A write to the low location loads counter bits 15:8 from the latch and bits 7:0 from `bus_wdata`, both at the same clock edge.
- R4: A low-location write leaves the latch unchanged, so a single high write serves any number of later low writes.
- R5: On a clock with `tick`=1 and `clk_sel`≠0, the counter rises by one when `count_down`=0 and falls by one when `count_down`=1. Both directions wrap modulo 2^16.
- R6: `clear`=1 zeroes the counter on a qualifying tick and takes priority over counting. Without a qualifying tick, `clear` has no effect.
- R7: With `clk_sel`=0 the counter holds its value whatever `tick` and `clear` do, and bus reads and writes still work.
- R8: A low-location write takes priority over clear and count in the same cycle.
- R9: `at_bottom` is 1 exactly when the counter is 0. `at_top` is 1 exactly when the counter equals `top_value`.
- R10: `ovf_flag` is set by an up-count step from 0xFFFF to 0x0000 and stays set until `ovf_clr` is pulsed, with set winning over a same-cycle clear. A down wrap does not set it, and neither does a bus write.
- R11: A synchronous active-high `rst` zeroes the counter, the latch and `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 selects the low location, 1 selects the high location |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| tick | input | 1 | Count-enable tick |
| count_down | input | 1 | 1 counts down, 0 counts up |
| clear | input | 1 | Zero the counter on a tick |
| clk_sel | input | 3 | Clock select; 0 stops counting |
| top_value | input | 16 | Compare value for `at_top` |
| ovf_clr | input | 1 | Write-one-to-clear for `ovf_flag` |
| at_top | output | 1 | Counter equals `top_value` |
| at_bottom | output | 1 | Counter equals zero |
| ovf_flag | output | 1 | Sticky up-wrap flag |

## Verification
The bench targets reuse of the holding latch. Two low writes with no high write between them must both take the same upper byte, so a design that cleared or reloaded the latch on a low write would lose it on the second write. A high write followed by a full readback catches a design that routes high writes straight into the counter. A low write issued while `tick` and `clear` are active catches a design that lets clear or count override the bus. A wrap from 0xFFFF upward, a wrap from zero downward and a direct write over 0xFFFF separate a correct sticky flag from one that fires on any wrap or on any transition to zero.

// File: rtl/bytebus_counter_pkg.sv
package bytebus_counter_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int SEL_W  = 3;

  typedef enum logic {LOC_LOW = 1'b0, LOC_HIGH = 1'b1} loc_e;

  // One counting step in the chosen direction, modulo 2^CNT_W.
  function automatic logic [CNT_W-1:0] step_value(input logic [CNT_W-1:0] cur,
                                                  input logic down);
    step_value = down ? cur - CNT_W'(1) : cur + CNT_W'(1);
  endfunction

  // True when an upward step leaves the all-ones value.
  function automatic logic wraps_upward(input logic [CNT_W-1:0] cur,
                                        input logic down);
    wraps_upward = !down && (cur == {CNT_W{1'b1}});
  endfunction
endpackage

// File: rtl/bytebus_counter_core.sv
module bytebus_counter_core
  import bytebus_counter_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run_en,
  input  logic             clear_en,
  input  logic             down,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_up
);
  logic [CNT_W-1:0] cnt_r;
  logic             step_ok;

  // A step happens only when the bus is quiet and clear is not asserted.
  assign step_ok = run_en && !clear_en && !load_en;
  assign wrap_up = step_ok && wraps_upward(cnt_r, down);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_r <= '0;
    end else if (load_en) begin
      cnt_r <= load_val;
    end else if (run_en && clear_en) begin
      cnt_r <= '0;
    end else if (run_en) begin
      cnt_r <= step_value(cnt_r, down);
    end
  end

  assign cnt = cnt_r;
endmodule

// File: rtl/bytebus_counter_bus.sv
module bytebus_counter_bus
  import bytebus_counter_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] temp,
  output logic              lo_write,
  output logic [CNT_W-1:0]  load_val
);
  logic [BYTE_W-1:0] temp_r;
  logic              hi_write;
  logic              lo_read;

  assign hi_write = wr && (loc_e'(addr) == LOC_HIGH);
  assign lo_write = wr && (loc_e'(addr) == LOC_LOW);
  assign lo_read  = rd && (loc_e'(addr) == LOC_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      temp_r <= '0;
    end else if (hi_write) begin
      temp_r <= wdata;
    end else if (lo_read) begin
      temp_r <= cnt[CNT_W-1:BYTE_W];
    end
  end

  assign load_val = {temp_r, wdata};
  assign rdata    = (loc_e'(addr) == LOC_HIGH) ? temp_r : cnt[BYTE_W-1:0];
  assign temp     = temp_r;
endmodule

// File: rtl/bytebus_counter_flags.sv
module bytebus_counter_flags
  import bytebus_counter_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] top_value,
  input  logic             wrap_up,
  input  logic             ovf_clr,
  output logic             at_top,
  output logic             at_bottom,
  output logic             ovf_flag
);
  logic ovf_r;

  always_ff @(posedge clk) begin
    if (rst)          ovf_r <= 1'b0;
    else if (wrap_up) ovf_r <= 1'b1;
    else if (ovf_clr) ovf_r <= 1'b0;
  end

  assign at_top    = (cnt == top_value);
  assign at_bottom = (cnt == '0);
  assign ovf_flag  = ovf_r;
endmodule

// File: rtl/bytebus_counter.sv
module bytebus_counter
  import bytebus_counter_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              tick,
  input  logic              count_down,
  input  logic              clear,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic [CNT_W-1:0]  top_value,
  input  logic              ovf_clr,
  output logic              at_top,
  output logic              at_bottom,
  output logic              ovf_flag
);
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] temp_q;
  logic [CNT_W-1:0]  load_val;
  logic              lo_write;
  logic              run_en;
  logic              wrap_up;

  assign run_en = tick && (clk_sel != '0);

  bytebus_counter_bus u_bus (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .cnt(cnt_q), .rdata(bus_rdata), .temp(temp_q),
    .lo_write(lo_write), .load_val(load_val)
  );

  bytebus_counter_core u_core (
    .clk(clk), .rst(rst), .load_en(lo_write), .load_val(load_val),
    .run_en(run_en), .clear_en(clear), .down(count_down),
    .cnt(cnt_q), .wrap_up(wrap_up)
  );

  bytebus_counter_flags u_flags (
    .clk(clk), .rst(rst), .cnt(cnt_q), .top_value(top_value),
    .wrap_up(wrap_up), .ovf_clr(ovf_clr), .at_top(at_top),
    .at_bottom(at_bottom), .ovf_flag(ovf_flag)
  );
endmodule

// File: rtl/bytebus_counter_chk.sv
module bytebus_counter_chk
  import bytebus_counter_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              tick,
  input logic              count_down,
  input logic              clear,
  input logic [SEL_W-1:0]  clk_sel,
  input logic              ovf_clr,
  input logic              at_bottom,
  input logic              ovf_flag,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [BYTE_W-1:0] temp_q,
  input logic              wrap_up
);
  logic lo_wr, run;
  assign lo_wr = bus_wr && !bus_addr;
  assign run   = tick && (clk_sel != '0);

  // R1
  p_hi_write_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr) |=> (temp_q == $past(bus_wdata)));
  // R2
  p_lo_read_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_addr) |=> (temp_q == $past(cnt_q[CNT_W-1:BYTE_W])));
  // R3
  p_commit_r3: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> (cnt_q == {$past(temp_q), $past(bus_wdata)}));
  // R4
  p_temp_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (lo_wr && !bus_rd) |=> $stable(temp_q));
  // R5
  p_up_step_r5: assert property (@(posedge clk) disable iff (rst)
    (run && !clear && !lo_wr && !count_down) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R6
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (run && clear && !lo_wr) |=> (cnt_q == '0));
  // R7
  p_stopped_r7: assert property (@(posedge clk) disable iff (rst)
    ((clk_sel == '0) && !lo_wr) |=> $stable(cnt_q));
  // R9
  p_bottom_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |-> at_bottom);
  // R10
  p_wrap_sets_r10: assert property (@(posedge clk) disable iff (rst)
    wrap_up |=> ovf_flag);
  // R10
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

bind bytebus_counter bytebus_counter_chk chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .tick(tick), .count_down(count_down), .clear(clear),
  .clk_sel(clk_sel), .ovf_clr(ovf_clr), .at_bottom(at_bottom),
  .ovf_flag(ovf_flag), .cnt_q(cnt_q), .temp_q(temp_q), .wrap_up(wrap_up)
);

// File: tb/bytebus_counter_tb_top.sv
`timescale 1ns/1ps
module bytebus_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_addr, bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        tick, count_down, clear, ovf_clr;
  logic [2:0]  clk_sel;
  logic [15:0] top_value;
  logic        at_top, at_bottom, ovf_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bytebus_counter dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .count_down(count_down), .clear(clear), .clk_sel(clk_sel),
    .top_value(top_value), .ovf_clr(ovf_clr), .at_top(at_top),
    .at_bottom(at_bottom), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; tick = 0; clear = 0; ovf_clr = 0;
  endtask

  // Drive at the falling edge, let one rising edge act, return at the next falling edge.
  task automatic bus_write(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic write16(input logic [15:0] v);
    bus_write(1'b1, v[15:8]);
    bus_write(1'b0, v[7:0]);
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_read(1'b0, lo);
    bus_read(1'b1, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n, input logic down);
    count_down = down; tick = 1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R11 ovf after reset", 16'(ovf_flag), 16'd0);
    check("R11 bottom after reset", 16'(at_bottom), 16'd1);
    bus_read(1'b1, v[7:0]);
    check("R11 latch after reset", 16'(v[7:0]), 16'h0);
    read16(v);
    check("R11 counter after reset", v, 16'h0000);
  endtask

  task automatic t_high_only();
    logic [7:0]  b;
    logic [15:0] v;
    bus_write(1'b1, 8'hAB);
    bus_read(1'b1, b);
    check("R1 high read returns latch", 16'(b), 16'h00AB);
    read16(v);
    check("R1 high write leaves counter", v, 16'h0000);
  endtask

  task automatic t_commit_and_read();
    logic [7:0]  b;
    logic [15:0] v;
    write16(16'h1234);
    bus_read(1'b0, b);
    check("R2 low read byte", 16'(b), 16'h0034);
    bus_read(1'b1, b);
    check("R2 latch captured upper byte", 16'(b), 16'h0012);
    bus_write(1'b1, 8'hC3);
    bus_write(1'b0, 8'h5A);
    read16(v);
    check("R3 16-bit commit", v, 16'hC35A);
  endtask

  task automatic t_reuse();
    logic [15:0] v;
    bus_write(1'b1, 8'h56);
    bus_write(1'b0, 8'h01);
    bus_write(1'b0, 8'h02);
    read16(v);
    check("R4 latch reused on second low write", v, 16'h5602);
  endtask

  task automatic t_count();
    logic [15:0] v;
    clk_sel = 3'd1;
    write16(16'h00FE);
    ticks(3, 1'b0);
    read16(v);
    check("R5 up three", v, 16'h0101);
    ticks(5, 1'b1);
    read16(v);
    check("R5 down five", v, 16'h00FC);
    write16(16'h0001);
    ticks(2, 1'b1);
    read16(v);
    check("R5 down wrap", v, 16'hFFFF);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    clk_sel = 3'd4;
    write16(16'h1234);
    clear = 1;
    @(posedge clk); @(negedge clk);
    read16(v);
    check("R6 clear without tick ignored", v, 16'h1234);
    clear = 1; count_down = 0; tick = 1;
    @(posedge clk); @(negedge clk);
    tick = 0; clear = 0;
    read16(v);
    check("R6 clear on tick", v, 16'h0000);
  endtask

  task automatic t_stopped();
    logic [15:0] v;
    clk_sel = 3'd0;
    write16(16'h4321);
    ticks(4, 1'b0);
    clear = 1; tick = 1;
    @(posedge clk); @(negedge clk);
    tick = 0; clear = 0;
    read16(v);
    check("R7 stopped counter holds", v, 16'h4321);
    write16(16'h0BEE);
    read16(v);
    check("R7 bus write while stopped", v, 16'h0BEE);
  endtask

  task automatic t_priority();
    logic [15:0] v;
    clk_sel = 3'd2;
    write16(16'h0010);
    bus_write(1'b1, 8'h77);
    tick = 1; clear = 1; count_down = 0;
    bus_write(1'b0, 8'h99);
    tick = 0; clear = 0;
    read16(v);
    check("R8 write beats clear", v, 16'h7799);
    bus_write(1'b1, 8'h20);
    tick = 1; count_down = 1;
    bus_write(1'b0, 8'h00);
    tick = 0;
    read16(v);
    check("R8 write beats count", v, 16'h2000);
  endtask

  task automatic t_flags();
    clk_sel = 3'd1;
    top_value = 16'h0003;
    write16(16'h0000);
    check("R9 bottom at zero", 16'(at_bottom), 16'd1);
    check("R9 top not yet", 16'(at_top), 16'd0);
    ticks(3, 1'b0);
    check("R9 top reached", 16'(at_top), 16'd1);
    check("R9 bottom cleared", 16'(at_bottom), 16'd0);
    top_value = 16'hFFFF;
  endtask

  task automatic t_ovf();
    clk_sel = 3'd1;
    write16(16'h0000);
    ticks(1, 1'b1);
    check("R10 down wrap no flag", 16'(ovf_flag), 16'd0);
    write16(16'h0000);
    check("R10 write over FFFF no flag", 16'(ovf_flag), 16'd0);
    write16(16'hFFFF);
    ticks(1, 1'b0);
    check("R10 up wrap sets flag", 16'(ovf_flag), 16'd1);
    check("R9 bottom after wrap", 16'(at_bottom), 16'd1);
    ticks(3, 1'b0);
    check("R10 flag sticky", 16'(ovf_flag), 16'd1);
    write16(16'hFFFF);
    ovf_clr = 1; tick = 1; count_down = 0;
    @(posedge clk); @(negedge clk);
    ovf_clr = 0; tick = 0;
    check("R10 set wins over clear", 16'(ovf_flag), 16'd1);
    ovf_clr = 1;
    @(posedge clk); @(negedge clk);
    ovf_clr = 0;
    check("R10 cleared by strobe", 16'(ovf_flag), 16'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    bus_addr = 0; bus_wdata = 0; count_down = 0; clk_sel = 0; top_value = 16'hFFFF;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_high_only();
    t_commit_and_read();
    t_reuse();
    t_count();
    t_clear();
    t_stopped();
    t_priority();
    t_flags();
    t_ovf();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule